// File: doc/BRIEF.md
# Dual-Slot Card Power Sequencer

This block sequences power for two card slots that share one supply converter. A step tick, derived by dividing the system clock, paces every change. One step tick is half of the sequencing period T. When the host asks a slot to start and the slot qualifies, the block turns the shared converter on. It then raises the slot's contact supply, then releases the data line to its pull-up, and finally enables the card clock and the reset control, each at a fixed number of half-T ticks.

The slot is torn down when the host withdraws its start request or a hardware fault is flagged. Teardown follows the reverse order, one T per step: reset control first, then the clock, then the data line, then the contact supply. The converter stays on for as long as either slot is busy. A loss of the shared supply tears down both slots on the same tick.

After a teardown caused by a fault or by a supply loss, the start request must be seen low before the slot accepts a new start.

Top module: `card_pwr_seq`

## Requirements
- R1: While reset is held and right after it, all outputs (converter, contact supply, data line, clock and reset enables of both slots) are low.
- R2: An idle slot stays idle, with the converter off if no other slot is busy, unless on a step tick all of these hold: start high, card present, no fault, supply good.
- R3: The converter enable rises on the step tick that accepts a start. If the other slot is already busy, the converter stays high without a break.
- R4: After acceptance, the contact supply enable rises 3 half-T ticks later, the data-line enable 7 ticks later, and the clock and reset enables together 8 ticks later (one half-T tick is HALF_DIV clock cycles).
- R5: A low start request or a high fault, seen on a step tick while a slot is busy, drops that slot's reset enable on that tick. The clock enable drops 2 ticks later, the data-line enable 2 ticks after that, and the contact supply 2 ticks after that.
- R6: The converter enable falls on the tick that removes the last busy slot's contact supply, and never while another slot is busy.
- R7: A low supply-good seen on a step tick starts teardown of both busy slots on that same tick.
- R8: A start request raised during teardown has no effect until teardown ends; it is then accepted on the next tick. After a teardown entered with start still high, the slot restarts only after start has been seen low on a tick.
- R9: Enables change only on step ticks, an idle slot drives all its enables low, and a slot never has reset without clock, clock without data line, or data line without contact supply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Shared supply good |
| start | input | NSLOT | Per-slot start request from the host |
| present | input | NSLOT | Per-slot card present |
| fault | input | NSLOT | Per-slot hardware fault |
| conv_en | output | 1 | Shared converter enable |
| vcc_en | output | NSLOT | Per-slot contact supply enable |
| io_en | output | NSLOT | Per-slot data line pull-up release |
| clk_en | output | NSLOT | Per-slot card clock enable |
| rst_en | output | NSLOT | Per-slot reset control enable |

## Verification
The bench builds the block with HALF_DIV set to 4 and two slots, so that one half-T tick is four clock cycles. With that setting, full power-up and teardown sequences, overlapping sessions on both slots and the restart-after-teardown cases all fit in a few hundred cycles. Every step spacing is checked as an exact cycle count, measured from the preceding observed edge. This makes the 3, 7 and 8 tick points, and the 2-tick teardown gaps, visible without any knowledge of the prescaler phase.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

  // Power-up points, counted in half-T ticks from acceptance
  localparam int unsigned STEP_VCC = 3;
  localparam int unsigned STEP_IO  = 7;
  localparam int unsigned STEP_RUN = 8;
  // Teardown spacing in half-T ticks (one T)
  localparam int unsigned DN_GAP   = 2;
  localparam int unsigned DN_LAST  = 3 * DN_GAP;
  localparam int unsigned STEP_W   = $clog2(STEP_RUN + 1);

  typedef logic [STEP_W-1:0] step_t;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_UP   = 2'd1,
    SLOT_ON   = 2'd2,
    SLOT_DN   = 2'd3
  } slot_state_t;

  typedef struct packed {
    logic vcc;
    logic io;
    logic clk;
    logic rst;
  } pins_t;

  // Enables for power-up step k
  function automatic pins_t up_pins(input step_t k);
    pins_t p;
    p.vcc = (k >= step_t'(STEP_VCC));
    p.io  = (k >= step_t'(STEP_IO));
    p.clk = (k >= step_t'(STEP_RUN));
    p.rst = (k >= step_t'(STEP_RUN));
    return p;
  endfunction

  // Enables for teardown step k, never re-enabling anything
  function automatic pins_t dn_pins(input step_t k, input pins_t prev);
    pins_t p;
    p.rst = 1'b0;
    p.clk = prev.clk && (k < step_t'(DN_GAP));
    p.io  = prev.io  && (k < step_t'(2 * DN_GAP));
    p.vcc = prev.vcc && (k < step_t'(DN_LAST));
    return p;
  endfunction

endpackage

// File: rtl/card_seq_prescale.sv
module card_seq_prescale #(
  parameter int unsigned HALF_DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == CNT_W'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (tick) cnt <= '0;
    else          cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/card_seq_slot.sv
module card_seq_slot
  import card_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  start,
  input  logic  present,
  input  logic  fault,
  input  logic  supply_ok,
  output pins_t pins,
  output logic  busy
);
  slot_state_t st;
  step_t       step;
  step_t       nxt;
  logic        need_low;
  logic        go;
  logic        drop;

  assign nxt  = step + step_t'(1);
  assign go   = start && present && !fault && supply_ok && !need_low;
  assign drop = !start || fault || !supply_ok;
  assign busy = (st != SLOT_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SLOT_IDLE;
      step     <= '0;
      pins     <= '0;
      need_low <= 1'b0;
    end else if (tick) begin
      if (!start) need_low <= 1'b0;
      unique case (st)
        SLOT_IDLE: begin
          step <= '0;
          if (go) st <= SLOT_UP;
        end
        SLOT_UP, SLOT_ON: begin
          if (drop) begin
            st       <= SLOT_DN;
            step     <= '0;
            pins.rst <= 1'b0;
            need_low <= start;
          end else if (st == SLOT_UP) begin
            step <= nxt;
            pins <= up_pins(nxt);
            if (nxt == step_t'(STEP_RUN)) st <= SLOT_ON;
          end
        end
        SLOT_DN: begin
          step <= nxt;
          pins <= dn_pins(nxt, pins);
          if (nxt == step_t'(DN_LAST)) st <= SLOT_IDLE;
        end
        default: st <= SLOT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/card_pwr_seq.sv
module card_pwr_seq
  import card_seq_pkg::*;
#(
  parameter int unsigned NSLOT    = 2,
  parameter int unsigned HALF_DIV = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic [NSLOT-1:0] start,
  input  logic [NSLOT-1:0] present,
  input  logic [NSLOT-1:0] fault,
  output logic             conv_en,
  output logic [NSLOT-1:0] vcc_en,
  output logic [NSLOT-1:0] io_en,
  output logic [NSLOT-1:0] clk_en,
  output logic [NSLOT-1:0] rst_en
);
  logic             step_tick;
  logic [NSLOT-1:0] slot_busy;
  pins_t            slot_pins [NSLOT];

  card_seq_prescale #(.HALF_DIV(HALF_DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (step_tick)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    card_seq_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (step_tick),
      .start     (start[g]),
      .present   (present[g]),
      .fault     (fault[g]),
      .supply_ok (supply_ok),
      .pins      (slot_pins[g]),
      .busy      (slot_busy[g])
    );
    assign vcc_en[g] = slot_pins[g].vcc;
    assign io_en[g]  = slot_pins[g].io;
    assign clk_en[g] = slot_pins[g].clk;
    assign rst_en[g] = slot_pins[g].rst;
  end

  // Shared converter: on while any slot holds a session or teardown
  assign conv_en = |slot_busy;
endmodule

// File: rtl/card_pwr_seq_chk.sv
module card_pwr_seq_chk #(
  parameter int unsigned NSLOT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             supply_ok,
  input logic [NSLOT-1:0] present,
  input logic [NSLOT-1:0] fault,
  input logic [NSLOT-1:0] busy,
  input logic             conv_en,
  input logic [NSLOT-1:0] vcc_en,
  input logic [NSLOT-1:0] io_en,
  input logic [NSLOT-1:0] clk_en,
  input logic [NSLOT-1:0] rst_en
);
  assert_tick_paced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable({vcc_en, io_en, clk_en, rst_en}));

  assert_drop_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !supply_ok |=> rst_en == '0);

  for (genvar i = 0; i < NSLOT; i++) begin : g_chk
    assert_rst_needs_clk_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_en[i] |-> clk_en[i]);
    assert_clk_needs_io_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en[i] |-> io_en[i]);
    assert_io_needs_vcc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      io_en[i] |-> vcc_en[i]);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy[i] |-> !(vcc_en[i] || io_en[i] || clk_en[i] || rst_en[i]));
    assert_vcc_has_conv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vcc_en[i] |-> conv_en);
    assert_fault_drops_rst_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tick && fault[i] |=> !rst_en[i]);
    assert_gate_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !busy[i] && (!present[i] || fault[i] || !supply_ok) |=> !busy[i]);
  end
endmodule

bind card_pwr_seq card_pwr_seq_chk #(.NSLOT(NSLOT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (step_tick),
  .supply_ok (supply_ok),
  .present   (present),
  .fault     (fault),
  .busy      (slot_busy),
  .conv_en   (conv_en),
  .vcc_en    (vcc_en),
  .io_en     (io_en),
  .clk_en    (clk_en),
  .rst_en    (rst_en)
);

// File: tb/sim_card_pwr_seq.sv
module sim_card_pwr_seq;
  localparam int H = 4;
  localparam int N = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         supply_ok = 1'b0;
  logic [N-1:0] start = '0;
  logic [N-1:0] present = '0;
  logic [N-1:0] fault = '0;
  logic         conv_en;
  logic [N-1:0] vcc_en, io_en, clk_en, rst_en;
  logic [8:0]   mon;

  int vec = 0;
  int bad = 0;
  int cyc = 0;

  card_pwr_seq #(.NSLOT(N), .HALF_DIV(H)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .start(start),
    .present(present), .fault(fault), .conv_en(conv_en), .vcc_en(vcc_en),
    .io_en(io_en), .clk_en(clk_en), .rst_en(rst_en)
  );

  // bit map: 0 conv, 1+s vcc, 3+s io, 5+s clk, 7+s rst
  assign mon = {rst_en, clk_en, io_en, vcc_en, conv_en};

  always #5 clk = ~clk;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      vec++; bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    vec++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wait_bit(input int b, input logic v, output int n);
    n = 0;
    while (mon[b] !== v && n < 64 * H) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idle_for(input int ticks);
    repeat (ticks * H) @(negedge clk);
  endtask

  task automatic act_slot(input int s, input bit conv_pre);
    int n;
    @(negedge clk);
    present[s] = 1'b1;
    start[s]   = 1'b1;
    if (!conv_pre) begin
      wait_bit(0, 1'b1, n);
      chk_rng("R3 converter on at acceptance", n, 1, H);
      wait_bit(1 + s, 1'b1, n);
      chk("R4 vcc 3 ticks after acceptance", n, 3 * H);
    end else begin
      wait_bit(1 + s, 1'b1, n);
      chk_rng("R4 vcc after start with shared converter", n, 3 * H + 1, 4 * H);
      chk("R3 converter held by other slot", int'(conv_en), 1);
    end
    wait_bit(3 + s, 1'b1, n);
    chk("R4 io 4 ticks after vcc", n, 4 * H);
    wait_bit(5 + s, 1'b1, n);
    chk("R4 clk 1 tick after io", n, H);
    chk("R4 rst with clk", int'(rst_en[s]), 1);
  endtask

  task automatic down_slot(input int s, input bit other_on);
    int n;
    wait_bit(7 + s, 1'b0, n);
    chk_rng("R5 rst drops on first tick", n, 1, H);
    wait_bit(5 + s, 1'b0, n);
    chk("R5 clk drops 2 ticks after rst", n, 2 * H);
    wait_bit(3 + s, 1'b0, n);
    chk("R5 io drops 2 ticks after clk", n, 2 * H);
    wait_bit(1 + s, 1'b0, n);
    chk("R5 vcc drops 2 ticks after io", n, 2 * H);
    chk("R6 converter state after slot off", int'(conv_en), int'(other_on));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 outputs low in reset", int'(mon), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs low after reset", int'(mon), 0);
  endtask

  task automatic t_blocked();
    supply_ok = 1'b1;
    start[0]  = 1'b1;
    idle_for(12);
    chk("R2 no card keeps slot idle", int'(mon), 0);
    present[0] = 1'b1;
    fault[0]   = 1'b1;
    idle_for(12);
    chk("R2 fault keeps slot idle", int'(mon), 0);
    fault[0]  = 1'b0;
    supply_ok = 1'b0;
    idle_for(12);
    chk("R2 supply low keeps slot idle", int'(mon), 0);
    start[0]  = 1'b0;
    supply_ok = 1'b1;
    idle_for(2);
  endtask

  task automatic t_two_sessions();
    act_slot(0, 1'b0);
    act_slot(1, 1'b1);
    @(negedge clk);
    start[0] = 1'b0;
    down_slot(0, 1'b1);
  endtask

  task automatic t_fault_rearm();
    int n;
    @(negedge clk);
    fault[1] = 1'b1;
    down_slot(1, 1'b0);
    fault[1] = 1'b0;
    idle_for(12);
    chk("R8 no restart before start seen low", int'(mon), 0);
    start[1] = 1'b0;
    idle_for(2);
    act_slot(1, 1'b0);
    n = 0;
  endtask

  task automatic t_request_in_teardown();
    int n;
    @(negedge clk);
    start[1] = 1'b0;
    wait_bit(8, 1'b0, n);
    chk_rng("R5 rst drops after start low", n, 1, H);
    start[1] = 1'b1;
    wait_bit(6, 1'b0, n);
    chk("R8 teardown continues clk", n, 2 * H);
    wait_bit(4, 1'b0, n);
    chk("R8 teardown continues io", n, 2 * H);
    wait_bit(2, 1'b0, n);
    chk("R8 teardown continues vcc", n, 2 * H);
    chk("R6 converter off with last slot", int'(conv_en), 0);
    wait_bit(0, 1'b1, n);
    chk("R8 restart on next tick", n, H);
    wait_bit(2, 1'b1, n);
    chk("R4 vcc after restart", n, 3 * H);
  endtask

  task automatic t_dropout();
    int n;
    act_slot(0, 1'b1);
    idle_for(2);
    @(negedge clk);
    supply_ok = 1'b0;
    wait_bit(7, 1'b0, n);
    chk_rng("R7 slot 0 rst drops", n, 1, H);
    chk("R7 slot 1 rst drops same tick", int'(rst_en[1]), 0);
    wait_bit(1, 1'b0, n);
    chk("R7 slot 0 vcc off", n, 6 * H);
    chk("R7 slot 1 vcc off same tick", int'(vcc_en[1]), 0);
    chk("R6 converter off after both", int'(conv_en), 0);
    supply_ok = 1'b1;
    idle_for(12);
    chk("R8 no restart after dropout", int'(mon), 0);
    start = '0;
  endtask

  initial begin
    t_reset();
    t_blocked();
    t_two_sessions();
    t_fault_rearm();
    t_request_in_teardown();
    t_dropout();
    idle_for(2);
    summary();
  end
endmodule